// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This unit guards a five-stage in-order integer pipeline against the single data dependence that bypassing cannot fix: an instruction that reads a register in the cycle right after a load has entered EX to produce that register. The loaded value only appears at the end of the load's memory cycle, too late for the dependent instruction's EX. The unit compares the load's destination in EX against the register sources that the instruction in ID actually uses. On a match it holds the program counter and the IF/ID register for one cycle. It also turns the instruction about to enter ID/EX into a bubble by clearing its register-write and memory-write enables.

After one stall cycle the load has moved on to MEM and the bubble sits in EX, so the consumer then picks up the loaded value through the normal bypass path. A consumer two instructions behind the load is covered by that bypass. A consumer three behind reads the register file after the write-back in the same cycle. In neither case is EX holding the load when the consumer is in ID, so the unit takes no action for them. The detection is combinational, so the stall controls are valid in the same cycle as the operands. A one-bit history register ensures that no hazard ever holds the pipeline for two cycles in a row.

Top module: `load_use_interlock`

## Requirements
- R1: When the EX class is LOAD (code 3'd2), its destination is non-zero and equals the ID rs1 field, and the ID class reads rs1, the same cycle shows pc_write=0, ifid_write=0 and bubble=1. The classes that read rs1 are ALU_RR (3'd0), ALU_IMM (3'd1), LOAD (3'd2), STORE (3'd3) and BRANCH (3'd4).
- R2: The same stall happens when the EX load destination equals the ID rs2 field and the ID class reads rs2. The classes that read rs2 are ALU_RR, STORE (as its data operand) and BRANCH.
- R3: A matching register field is ignored when the ID class does not read it: rs2 for ALU_IMM or LOAD, and both fields for JUMP (3'd5), UPPER (3'd6) and NOP (3'd7). In these cases pc_write=1, ifid_write=1 and bubble=0.
- R4: A load whose destination is register 0 never causes a stall.
- R5: An EX instruction of any class other than LOAD never causes a stall. This covers the cycles in which the load has already moved past EX.
- R6: While bubble=1, idex_reg_we and idex_mem_we are 0. While bubble=0, they equal id_reg_we and id_mem_we.
- R7: A stall lasts exactly one cycle. In the cycle after bubble=1, bubble is 0 even if the hazard inputs are unchanged. A hazard that is still present one cycle later stalls again.
- R8: While rst_n is low, no stall is signalled (pc_write=1, ifid_write=1, bubble=0), and the one-cycle history is cleared by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_class | input | 3 | Operation class of the instruction in ID |
| id_rs1 | input | 5 | First source register field in ID |
| id_rs2 | input | 5 | Second source register field in ID |
| id_reg_we | input | 1 | Register-write enable decoded in ID |
| id_mem_we | input | 1 | Memory-write enable decoded in ID |
| ex_class | input | 3 | Operation class of the instruction in EX |
| ex_rd | input | 5 | Destination register of the instruction in EX |
| pc_write | output | 1 | Program counter update enable (0 = hold) |
| ifid_write | output | 1 | IF/ID register update enable (0 = hold) |
| bubble | output | 1 | High when ID/EX receives a bubble |
| idex_reg_we | output | 1 | Register-write enable passed into ID/EX |
| idex_mem_we | output | 1 | Memory-write enable passed into ID/EX |

## Verification
Every stall control and gated enable is combinational from the inputs, so each result belongs to the same cycle as its stimulus. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. The only registered effect is the one-cycle history behind R7. Its check keeps a hazard applied across one rising edge and expects bubble low in the following cycle and high again in the cycle after. The R8 check clears reset in the same way and looks one cycle later.

// File: rtl/hz_pkg.sv
// Shared definitions for the load-use interlock.
// Assumes a 3-bit operation class supplied by the decoder of each stage.
package hz_pkg;
    typedef enum logic [2:0] {
        CLS_ALU_RR  = 3'd0,
        CLS_ALU_IMM = 3'd1,
        CLS_LOAD    = 3'd2,
        CLS_STORE   = 3'd3,
        CLS_BRANCH  = 3'd4,
        CLS_JUMP    = 3'd5,
        CLS_UPPER   = 3'd6,
        CLS_NOP     = 3'd7
    } op_class_e;

    localparam int unsigned CLASS_W = 3;
endpackage

// File: rtl/hz_src_use.sv
// Source-usage decoder: tells which register fields the ID instruction reads.
// Assumes index 0 is rs1 and index 1 is rs2; unknown classes read nothing.
module hz_src_use
    import hz_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  logic [CLASS_W-1:0] op_class,
    output logic [N_SRC-1:0]   src_used
);
    // Map each class to the set of register fields it consumes.
    always_comb begin
        src_used = '0;
        case (op_class_e'(op_class))
            CLS_ALU_RR:  src_used[1:0] = 2'b11;
            CLS_ALU_IMM: src_used[1:0] = 2'b01;
            CLS_LOAD:    src_used[1:0] = 2'b01;
            CLS_STORE:   src_used[1:0] = 2'b11;
            CLS_BRANCH:  src_used[1:0] = 2'b11;
            default:     src_used      = '0;
        endcase
    end
endmodule

// File: rtl/hz_match.sv
// Destination/source comparator bank: one comparator per source field.
// Assumes register 0 is hard-wired to zero, so it never carries a dependence.
module hz_match
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned N_SRC = 2
) (
    input  logic                        ex_is_load,
    input  logic [REG_W-1:0]            ex_rd,
    input  logic [N_SRC-1:0][REG_W-1:0] id_src,
    input  logic [N_SRC-1:0]            src_used,
    output logic                        hazard
);
    logic             rd_live;
    logic [N_SRC-1:0] hit;

    // A load writing a real register is the only producer of interest.
    assign rd_live = ex_is_load && (ex_rd != '0);

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
            // Compare one used source field against the load destination.
            assign hit[g] = rd_live && src_used[g] && (id_src[g] == ex_rd);
        end
    endgenerate

    // Any hit is a load-use dependence.
    assign hazard = |hit;
endmodule

// File: rtl/hz_stall_ctrl.sv
// Stall controller: turns a detected hazard into hold and bubble controls.
// Assumes the pipeline advances one stage per cycle when not held; the
// history bit caps every stall at a single cycle.
module hz_stall_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    input  logic id_reg_we,
    input  logic id_mem_we,
    output logic pc_write,
    output logic ifid_write,
    output logic bubble,
    output logic idex_reg_we,
    output logic idex_mem_we
);
    logic stalled_q;
    logic stall;

    // Stall only outside reset and never in the cycle after a stall.
    assign stall = hazard && !stalled_q && rst_n;

    // Remember whether the previous cycle was a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= stall;
    end

    // Hold the front end and kill the side effects of the entering slot.
    always_comb begin
        pc_write    = !stall;
        ifid_write  = !stall;
        bubble      = stall;
        idex_reg_we = id_reg_we && !stall;
        idex_mem_we = id_mem_we && !stall;
    end

    // R7: a stall is never followed directly by another.
    assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    // R6: a bubble carries no write enables.
    assert_bubble_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!idex_reg_we && !idex_mem_we));
endmodule

// File: rtl/load_use_interlock.sv
// Load-use interlock top: decodes the ID source usage, compares it with the
// EX load destination and drives the hold and bubble controls.
// Assumes the decoders of ID and EX present the class and register fields.
module load_use_interlock
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         id_class,
    input  logic [REG_W-1:0]   id_rs1,
    input  logic [REG_W-1:0]   id_rs2,
    input  logic               id_reg_we,
    input  logic               id_mem_we,
    input  logic [2:0]         ex_class,
    input  logic [REG_W-1:0]   ex_rd,
    output logic               pc_write,
    output logic               ifid_write,
    output logic               bubble,
    output logic               idex_reg_we,
    output logic               idex_mem_we
);
    localparam int unsigned N_SRC = 2;

    logic [N_SRC-1:0]            src_used;
    logic [N_SRC-1:0][REG_W-1:0] id_src;
    logic                        ex_is_load;
    logic                        hazard;

    // Gather the source fields and flag a load in EX.
    assign id_src     = {id_rs2, id_rs1};
    assign ex_is_load = (op_class_e'(ex_class) == CLS_LOAD);

    hz_src_use #(.N_SRC(N_SRC)) u_use (
        .op_class (id_class),
        .src_used (src_used)
    );

    hz_match #(.REG_W(REG_W), .N_SRC(N_SRC)) u_match (
        .ex_is_load (ex_is_load),
        .ex_rd      (ex_rd),
        .id_src     (id_src),
        .src_used   (src_used),
        .hazard     (hazard)
    );

    hz_stall_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hazard      (hazard),
        .id_reg_we   (id_reg_we),
        .id_mem_we   (id_mem_we),
        .pc_write    (pc_write),
        .ifid_write  (ifid_write),
        .bubble      (bubble),
        .idex_reg_we (idex_reg_we),
        .idex_mem_we (idex_mem_we)
    );

    // R5: only a load in EX can hold the pipeline.
    assert_load_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_class != 3'd2) |-> !bubble);

    // R4: a load into register 0 is never waited on.
    assert_zero_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !bubble);

    // R1: hold and bubble always appear together.
    assert_hold_with_bubble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!pc_write && !ifid_write));

    // R3: an instruction that reads no register is never stalled.
    assert_no_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_class >= 3'd5) |-> !bubble);
endmodule

// File: tb/load_use_interlock_bench.sv
// Directed bench for the load-use interlock.
module load_use_interlock_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] id_class = 3'd7;
    logic [4:0] id_rs1 = '0;
    logic [4:0] id_rs2 = '0;
    logic       id_reg_we = 1'b0;
    logic       id_mem_we = 1'b0;
    logic [2:0] ex_class = 3'd7;
    logic [4:0] ex_rd = '0;
    logic       pc_write, ifid_write, bubble, idex_reg_we, idex_mem_we;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_use_interlock u_load_use_interlock (
        .clk(clk), .rst_n(rst_n), .id_class(id_class), .id_rs1(id_rs1),
        .id_rs2(id_rs2), .id_reg_we(id_reg_we), .id_mem_we(id_mem_we),
        .ex_class(ex_class), .ex_rd(ex_rd), .pc_write(pc_write),
        .ifid_write(ifid_write), .bubble(bubble), .idex_reg_we(idex_reg_we),
        .idex_mem_we(idex_mem_we)
    );

    // Compare the three stall controls with the expected stall state.
    task automatic check_stall(input string req, input bit exp_stall);
        logic [2:0] act, exp;
        act = {pc_write, ifid_write, bubble};
        exp = {!exp_stall, !exp_stall, exp_stall};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pc/ifid/bubble act=%b exp=%b", req, act, exp);
        end
    endtask

    // Move to a new cycle and apply ID and EX fields.
    task automatic apply(input logic [2:0] ic, input logic [4:0] r1, input logic [4:0] r2,
                         input logic [2:0] ec, input logic [4:0] rd);
        @(negedge clk);
        id_class = ic; id_rs1 = r1; id_rs2 = r2; ex_class = ec; ex_rd = rd;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(3'd0, 5'd4, 5'd4, 3'd2, 5'd4);
        check_stall("R8 hazard held in reset", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        check_stall("R8 idle after reset", 1'b0);
    endtask

    task automatic t_rs1;
        apply(3'd0, 5'd6, 5'd9, 3'd2, 5'd6); check_stall("R1 alu_rr rs1", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd1, 5'd12, 5'd0, 3'd2, 5'd12); check_stall("R1 alu_imm rs1", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd2, 5'd31, 5'd1, 3'd2, 5'd31); check_stall("R1 load base rs1", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd4, 5'd3, 5'd8, 3'd2, 5'd3); check_stall("R1 branch rs1", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
    endtask

    task automatic t_rs2;
        apply(3'd0, 5'd1, 5'd7, 3'd2, 5'd7); check_stall("R2 alu_rr rs2", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd3, 5'd2, 5'd7, 3'd2, 5'd7); check_stall("R2 store data rs2", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd4, 5'd2, 5'd19, 3'd2, 5'd19); check_stall("R2 branch rs2", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        apply(3'd0, 5'd1, 5'd2, 3'd2, 5'd3); check_stall("R2 no match", 1'b0);
    endtask

    task automatic t_unused;
        apply(3'd1, 5'd1, 5'd9, 3'd2, 5'd9); check_stall("R3 alu_imm rs2 unused", 1'b0);
        apply(3'd2, 5'd1, 5'd9, 3'd2, 5'd9); check_stall("R3 load rs2 unused", 1'b0);
        for (int c = 5; c < 8; c++) begin
            apply(3'(c), 5'd9, 5'd9, 3'd2, 5'd9);
            check_stall($sformatf("R3 class %0d reads nothing", c), 1'b0);
        end
    endtask

    task automatic t_zero;
        apply(3'd0, 5'd0, 5'd0, 3'd2, 5'd0); check_stall("R4 load to r0", 1'b0);
    endtask

    task automatic t_nonload;
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                apply(3'd0, 5'd5, 5'd5, 3'(c), 5'd5);
                check_stall($sformatf("R5 ex class %0d", c), 1'b0);
            end
        end
    endtask

    task automatic t_enables;
        id_reg_we = 1'b1; id_mem_we = 1'b1;
        apply(3'd3, 5'd8, 5'd11, 3'd2, 5'd11);
        total++;
        if ({bubble, idex_reg_we, idex_mem_we} !== 3'b100) begin
            bad++;
            $display("FAIL R6 bubble/reg_we/mem_we act=%b exp=100",
                     {bubble, idex_reg_we, idex_mem_we});
        end
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
        total++;
        if ({bubble, idex_reg_we, idex_mem_we} !== 3'b011) begin
            bad++;
            $display("FAIL R6 pass-through act=%b exp=011",
                     {bubble, idex_reg_we, idex_mem_we});
        end
        id_reg_we = 1'b0; id_mem_we = 1'b1;
        #1;
        total++;
        if ({idex_reg_we, idex_mem_we} !== 2'b01) begin
            bad++;
            $display("FAIL R6 mixed pass-through act=%b exp=01", {idex_reg_we, idex_mem_we});
        end
        id_mem_we = 1'b0;
    endtask

    task automatic t_one_cycle;
        apply(3'd0, 5'd14, 5'd0, 3'd2, 5'd14); check_stall("R7 first cycle", 1'b1);
        @(negedge clk); #1; check_stall("R7 second cycle released", 1'b0);
        @(negedge clk); #1; check_stall("R7 third cycle stalls again", 1'b1);
        apply(3'd7, 5'd0, 5'd0, 3'd7, 5'd0);
    endtask

    initial begin
        t_reset();
        t_rs1();
        t_rs2();
        t_unused();
        t_zero();
        t_nonload();
        t_enables();
        t_one_cycle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule